// File: doc/BRIEF.md
# Synthesizer Serial Programming Latch Decoder

This block takes programming words for a frequency synthesizer over a three-wire serial link: a serial clock, a serial data line and a latch enable. Bits enter a 24-bit shift register most significant bit first, one on each rising edge of the serial clock. When latch enable rises, the two lowest bits of the word select its destination: the control latch, the reference (R) counter latch, the N counter latch or a test latch. The selected destination then takes the word, and the decoded fields are held on registered outputs.

All three serial lines are sampled by the system clock, and their edges are found in that domain. The charge pump gain bit has two sources. The control latch can write it, and so can the N counter latch. The output always shows the value from the more recent of those two loads. A word sent to the test latch has no effect on any field output. Every completed load produces a single-cycle update strobe, whatever its destination.

Top module: `synth_prog_latch`

## Requirements
- R1: Serial data is shifted in MSB first, one bit per rising serial clock edge. A load uses the last 24 bits shifted, and any earlier bits are discarded.
- R2: Outputs change only on a load, which is triggered by a rising edge of latch enable. Serial clocking without a latch enable edge leaves every output unchanged.
- R3: Word bits [1:0] = 01 load the R latch. The reference divide is taken from bits [15:2], antibacklash width from [17:16], lock detect precision from [18], test mode bit from [19] and band select clock divider from [21:20]. Bits [23:22] are ignored.
- R4: Word bits [1:0] = 10 load the N latch. The A count is taken from bits [6:2], the B count from [20:8], charge pump gain from [21], output divide-by-2 from [22] and divide-by-2 prescaler select from [23]. Bit 7 is ignored.
- R5: Word bits [1:0] = 00 load the control latch. Its bit 10 writes the charge pump gain, and no R or N field changes.
- R6: The charge pump gain output always equals the gain bit of the most recent control or N latch load.
- R7: Word bits [1:0] = 11 address the test latch. Such a load changes no field output.
- R8: Reset clears every field output and the update strobe to zero.
- R9: Every load raises the update strobe for exactly one cycle. The strobe is high during the second system clock cycle after latch enable is first high at a sampling edge. Decoded fields are valid in that same cycle.
- R10: An R latch load leaves the N latch fields unchanged. An N latch load leaves the R latch fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_le_i | input | 1 | Latch enable; rising edge loads the word |
| ref_div_o | output | 14 | Reference counter divide ratio |
| abp_width_o | output | 2 | Antibacklash pulse width code |
| ld_prec_o | output | 1 | Lock detect precision |
| test_mode_o | output | 1 | Test mode bit |
| bs_clk_div_o | output | 2 | Band select clock divider code |
| a_count_o | output | 5 | A counter value |
| b_count_o | output | 13 | B counter value |
| cp_gain_o | output | 1 | Charge pump gain (1 = current setting 2) |
| out_div2_o | output | 1 | Output divide-by-2 enable |
| div2_presc_o | output | 1 | Divided output feeds prescaler |
| upd_o | output | 1 | One-cycle update strobe |

## Verification
Each serial line passes through one input register before edge detection. A serial clock rise therefore shifts its bit two system clocks after the bench drives it. For the same reason, the update strobe and the new field values appear two system clocks after latch enable is driven high. The bench drives inputs on falling clock edges and waits exactly two rising edges after raising latch enable. It then samples at the next falling edge and expects the strobe high and the fields updated. One cycle later it expects the strobe low. In the no-load and test-latch cases, the bench checks after the same delay that every output still holds its earlier value.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'b00,
        SEL_RCNT = 2'b01,
        SEL_NCNT = 2'b10,
        SEL_TEST = 2'b11
    } latch_sel_e;

endpackage

// File: rtl/serial_shifter.sv
module serial_shifter #(
    parameter int unsigned WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_data_i,
    input  logic              ser_le_i,
    output logic [WORD_W-1:0] word_o,
    output logic              load_o
);

    typedef struct packed {
        logic              sclk;
        logic              sdat;
        logic              le;
        logic              sclk_prev;
        logic              le_prev;
        logic [WORD_W-1:0] sr;
    } shf_t;

    shf_t st_d, st_q;
    logic shift_en;

    assign shift_en = st_q.sclk & ~st_q.sclk_prev;
    assign load_o   = st_q.le & ~st_q.le_prev;
    assign word_o   = st_q.sr;

    always_comb begin
        st_d           = st_q;
        st_d.sclk      = ser_clk_i;
        st_d.sdat      = ser_data_i;
        st_d.le        = ser_le_i;
        st_d.sclk_prev = st_q.sclk;
        st_d.le_prev   = st_q.le;
        if (shift_en) begin
            st_d.sr = {st_q.sr[WORD_W-2:0], st_q.sdat};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);

endmodule

// File: rtl/field_unpack.sv
module field_unpack
    import synth_prog_pkg::*;
#(
    parameter int unsigned WORD_W   = 24,
    parameter int unsigned RDIV_W   = 14,
    parameter int unsigned ACNT_W   = 5,
    parameter int unsigned BCNT_W   = 13,
    parameter int unsigned CTRL_CPG = 10
) (
    input  logic [WORD_W-1:0] word_i,
    output latch_sel_e        sel_o,
    output logic [RDIV_W-1:0] rdiv_o,
    output logic [1:0]        abp_o,
    output logic              ldp_o,
    output logic              tmb_o,
    output logic [1:0]        bsc_o,
    output logic [ACNT_W-1:0] acnt_o,
    output logic [BCNT_W-1:0] bcnt_o,
    output logic              n_cpg_o,
    output logic              d2_o,
    output logic              d2s_o,
    output logic              c_cpg_o
);

    localparam int unsigned SEL_W   = 2;
    localparam int unsigned RDIV_LO = SEL_W;
    localparam int unsigned ABP_LO  = RDIV_LO + RDIV_W;
    localparam int unsigned LDP_B   = ABP_LO + 2;
    localparam int unsigned TMB_B   = LDP_B + 1;
    localparam int unsigned BSC_LO  = TMB_B + 1;
    localparam int unsigned ACNT_LO = SEL_W;
    localparam int unsigned RSV_B   = ACNT_LO + ACNT_W;
    localparam int unsigned BCNT_LO = RSV_B + 1;
    localparam int unsigned NCPG_B  = BCNT_LO + BCNT_W;
    localparam int unsigned D2_B    = NCPG_B + 1;
    localparam int unsigned D2S_B   = D2_B + 1;

    always_comb begin
        sel_o   = latch_sel_e'(word_i[SEL_W-1:0]);
        rdiv_o  = word_i[RDIV_LO +: RDIV_W];
        abp_o   = word_i[ABP_LO +: 2];
        ldp_o   = word_i[LDP_B];
        tmb_o   = word_i[TMB_B];
        bsc_o   = word_i[BSC_LO +: 2];
        acnt_o  = word_i[ACNT_LO +: ACNT_W];
        bcnt_o  = word_i[BCNT_LO +: BCNT_W];
        n_cpg_o = word_i[NCPG_B];
        d2_o    = word_i[D2_B];
        d2s_o   = word_i[D2S_B];
        c_cpg_o = word_i[CTRL_CPG];
    end

endmodule

// File: rtl/latch_bank.sv
module latch_bank
    import synth_prog_pkg::*;
#(
    parameter int unsigned RDIV_W = 14,
    parameter int unsigned ACNT_W = 5,
    parameter int unsigned BCNT_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  latch_sel_e        sel_i,
    input  logic [RDIV_W-1:0] rdiv_i,
    input  logic [1:0]        abp_i,
    input  logic              ldp_i,
    input  logic              tmb_i,
    input  logic [1:0]        bsc_i,
    input  logic [ACNT_W-1:0] acnt_i,
    input  logic [BCNT_W-1:0] bcnt_i,
    input  logic              n_cpg_i,
    input  logic              d2_i,
    input  logic              d2s_i,
    input  logic              c_cpg_i,
    output logic [RDIV_W-1:0] rdiv_o,
    output logic [1:0]        abp_o,
    output logic              ldp_o,
    output logic              tmb_o,
    output logic [1:0]        bsc_o,
    output logic [ACNT_W-1:0] acnt_o,
    output logic [BCNT_W-1:0] bcnt_o,
    output logic              cpg_o,
    output logic              d2_o,
    output logic              d2s_o,
    output logic              upd_o
);

    typedef struct packed {
        logic [RDIV_W-1:0] rdiv;
        logic [1:0]        abp;
        logic              ldp;
        logic              tmb;
        logic [1:0]        bsc;
        logic [ACNT_W-1:0] acnt;
        logic [BCNT_W-1:0] bcnt;
        logic              cpg;
        logic              d2;
        logic              d2s;
        logic              upd;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (load_i) begin
            st_d.upd = 1'b1;
            unique case (sel_i)
                SEL_RCNT: begin
                    st_d.rdiv = rdiv_i;
                    st_d.abp  = abp_i;
                    st_d.ldp  = ldp_i;
                    st_d.tmb  = tmb_i;
                    st_d.bsc  = bsc_i;
                end
                SEL_NCNT: begin
                    st_d.acnt = acnt_i;
                    st_d.bcnt = bcnt_i;
                    st_d.cpg  = n_cpg_i;
                    st_d.d2   = d2_i;
                    st_d.d2s  = d2s_i;
                end
                SEL_CTRL: begin
                    st_d.cpg = c_cpg_i;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdiv_o = st_q.rdiv;
    assign abp_o  = st_q.abp;
    assign ldp_o  = st_q.ldp;
    assign tmb_o  = st_q.tmb;
    assign bsc_o  = st_q.bsc;
    assign acnt_o = st_q.acnt;
    assign bcnt_o = st_q.bcnt;
    assign cpg_o  = st_q.cpg;
    assign d2_o   = st_q.d2;
    assign d2s_o  = st_q.d2s;
    assign upd_o  = st_q.upd;

    // R10
    r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.rdiv) |-> $past(load_i && sel_i == SEL_RCNT));

    // R10
    n_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.bcnt) |-> $past(load_i && sel_i == SEL_NCNT));

    // R6
    cpg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.cpg) |-> $past(load_i && (sel_i == SEL_NCNT || sel_i == SEL_CTRL)));

    // R7
    tst_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && sel_i == SEL_TEST) |=> ($stable(st_q.rdiv) && $stable(st_q.acnt)
                                           && $stable(st_q.cpg) && $stable(st_q.tmb)));

    // R9
    upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.upd |=> !st_q.upd);

endmodule

// File: rtl/synth_prog_latch.sv
module synth_prog_latch
    import synth_prog_pkg::*;
#(
    parameter int unsigned WORD_W   = 24,
    parameter int unsigned RDIV_W   = 14,
    parameter int unsigned ACNT_W   = 5,
    parameter int unsigned BCNT_W   = 13,
    parameter int unsigned CTRL_CPG = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_data_i,
    input  logic              ser_le_i,
    output logic [RDIV_W-1:0] ref_div_o,
    output logic [1:0]        abp_width_o,
    output logic              ld_prec_o,
    output logic              test_mode_o,
    output logic [1:0]        bs_clk_div_o,
    output logic [ACNT_W-1:0] a_count_o,
    output logic [BCNT_W-1:0] b_count_o,
    output logic              cp_gain_o,
    output logic              out_div2_o,
    output logic              div2_presc_o,
    output logic              upd_o
);

    logic [WORD_W-1:0] word;
    logic              load;
    latch_sel_e        sel;
    logic [RDIV_W-1:0] f_rdiv;
    logic [1:0]        f_abp;
    logic              f_ldp;
    logic              f_tmb;
    logic [1:0]        f_bsc;
    logic [ACNT_W-1:0] f_acnt;
    logic [BCNT_W-1:0] f_bcnt;
    logic              f_ncpg;
    logic              f_d2;
    logic              f_d2s;
    logic              f_ccpg;

    serial_shifter #(.WORD_W(WORD_W)) u_shf (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk_i  (ser_clk_i),
        .ser_data_i (ser_data_i),
        .ser_le_i   (ser_le_i),
        .word_o     (word),
        .load_o     (load)
    );

    field_unpack #(
        .WORD_W   (WORD_W),
        .RDIV_W   (RDIV_W),
        .ACNT_W   (ACNT_W),
        .BCNT_W   (BCNT_W),
        .CTRL_CPG (CTRL_CPG)
    ) u_unp (
        .word_i  (word),
        .sel_o   (sel),
        .rdiv_o  (f_rdiv),
        .abp_o   (f_abp),
        .ldp_o   (f_ldp),
        .tmb_o   (f_tmb),
        .bsc_o   (f_bsc),
        .acnt_o  (f_acnt),
        .bcnt_o  (f_bcnt),
        .n_cpg_o (f_ncpg),
        .d2_o    (f_d2),
        .d2s_o   (f_d2s),
        .c_cpg_o (f_ccpg)
    );

    latch_bank #(
        .RDIV_W (RDIV_W),
        .ACNT_W (ACNT_W),
        .BCNT_W (BCNT_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .sel_i   (sel),
        .rdiv_i  (f_rdiv),
        .abp_i   (f_abp),
        .ldp_i   (f_ldp),
        .tmb_i   (f_tmb),
        .bsc_i   (f_bsc),
        .acnt_i  (f_acnt),
        .bcnt_i  (f_bcnt),
        .n_cpg_i (f_ncpg),
        .d2_i    (f_d2),
        .d2s_i   (f_d2s),
        .c_cpg_i (f_ccpg),
        .rdiv_o  (ref_div_o),
        .abp_o   (abp_width_o),
        .ldp_o   (ld_prec_o),
        .tmb_o   (test_mode_o),
        .bsc_o   (bs_clk_div_o),
        .acnt_o  (a_count_o),
        .bcnt_o  (b_count_o),
        .cpg_o   (cp_gain_o),
        .d2_o    (out_div2_o),
        .d2s_o   (div2_presc_o),
        .upd_o   (upd_o)
    );

endmodule

// File: tb/synth_prog_latch_test.sv
`timescale 1ns/1ps
module synth_prog_latch_test;

    typedef struct packed {
        logic [23:0] word;
        logic [13:0] rdiv;
        logic [1:0]  abp;
        logic        ldp;
        logic        tmb;
        logic [1:0]  bsc;
        logic [4:0]  acnt;
        logic [12:0] bcnt;
        logic        cpg;
        logic        d2;
        logic        d2s;
    } vec_t;

    // Expected outputs after each word, cumulative state
    localparam vec_t VEC [7] = '{
        '{24'h360005, 14'd1,     2'd2, 1'b1, 1'b0, 2'd3, 5'd0,  13'd0,    1'b0, 1'b0, 1'b0}, // R3
        '{24'hBFFFFE, 14'd1,     2'd2, 1'b1, 1'b0, 2'd3, 5'd31, 13'd8191, 1'b1, 1'b0, 1'b1}, // R4 bit7 ignored
        '{24'h0003F0, 14'd1,     2'd2, 1'b1, 1'b0, 2'd3, 5'd31, 13'd8191, 1'b0, 1'b0, 1'b1}, // R5 cpg=0
        '{24'hFFFFFF, 14'd1,     2'd2, 1'b1, 1'b0, 2'd3, 5'd31, 13'd8191, 1'b0, 1'b0, 1'b1}, // R7 test latch
        '{24'h000400, 14'd1,     2'd2, 1'b1, 1'b0, 2'd3, 5'd31, 13'd8191, 1'b1, 1'b0, 1'b1}, // R5 R6 cpg=1
        '{24'hC8FFFD, 14'd16383, 2'd0, 1'b0, 1'b1, 2'd0, 5'd31, 13'd8191, 1'b1, 1'b0, 1'b1}, // R3 R10
        '{24'h400302, 14'd16383, 2'd0, 1'b0, 1'b1, 2'd0, 5'd0,  13'd3,    1'b0, 1'b1, 1'b0}  // R4 R6 R10
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sdat = 1'b0;
    logic sle = 1'b0;

    logic [13:0] ref_div;
    logic [1:0]  abp_width;
    logic        ld_prec;
    logic        test_mode;
    logic [1:0]  bs_clk_div;
    logic [4:0]  a_count;
    logic [12:0] b_count;
    logic        cp_gain;
    logic        out_div2;
    logic        div2_presc;
    logic        upd;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    synth_prog_latch uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ser_clk_i    (sclk),
        .ser_data_i   (sdat),
        .ser_le_i     (sle),
        .ref_div_o    (ref_div),
        .abp_width_o  (abp_width),
        .ld_prec_o    (ld_prec),
        .test_mode_o  (test_mode),
        .bs_clk_div_o (bs_clk_div),
        .a_count_o    (a_count),
        .b_count_o    (b_count),
        .cp_gain_o    (cp_gain),
        .out_div2_o   (out_div2),
        .div2_presc_o (div2_presc),
        .upd_o        (upd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag, input vec_t v);
        chk({tag, " R3 ref_div"},    32'(ref_div),    32'(v.rdiv));
        chk({tag, " R3 abp"},        32'(abp_width),  32'(v.abp));
        chk({tag, " R3 ldp"},        32'(ld_prec),    32'(v.ldp));
        chk({tag, " R3 tmb"},        32'(test_mode),  32'(v.tmb));
        chk({tag, " R3 bsc"},        32'(bs_clk_div), 32'(v.bsc));
        chk({tag, " R4 a_count"},    32'(a_count),    32'(v.acnt));
        chk({tag, " R4 b_count"},    32'(b_count),    32'(v.bcnt));
        chk({tag, " R6 cp_gain"},    32'(cp_gain),    32'(v.cpg));
        chk({tag, " R4 out_div2"},   32'(out_div2),   32'(v.d2));
        chk({tag, " R4 div2_presc"}, 32'(div2_presc), 32'(v.d2s));
    endtask

    task automatic shift_bits(input logic [31:0] w, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            @(negedge clk) sdat = w[i];
            @(negedge clk) sclk = 1'b1;
            @(negedge clk) sclk = 1'b0;
        end
        @(negedge clk);
    endtask

    // Raise LE and sample in the cycle the strobe is due (R9)
    task automatic pulse_le(input string tag);
        sle = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R9 upd early"}, 32'(upd), 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R9 upd due"}, 32'(upd), 32'd1);
        sle = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R9 upd single"}, 32'(upd), 32'd0);
    endtask

    vec_t zero_v;
    vec_t hold_v;

    initial begin
        zero_v = '0;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk_state("R8 in reset", zero_v);
        chk("R8 upd reset", 32'(upd), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        for (int k = 0; k < 7; k++) begin
            shift_bits(32'(VEC[k].word), 24);
            pulse_le($sformatf("vec%0d", k));
            chk_state($sformatf("vec%0d", k), VEC[k]);
        end

        // R2: shifting without LE edge leaves outputs alone
        hold_v = VEC[6];
        shift_bits(32'h000009, 24);
        repeat (4) @(negedge clk);
        chk_state("R2 no LE", hold_v);
        chk("R2 upd idle", 32'(upd), 32'd0);

        // R1: overlong burst, only last 24 bits count (r=2)
        shift_bits(32'h0F000009, 28);
        pulse_le("R1 long");
        hold_v.rdiv = 14'd2;
        hold_v.abp  = 2'd0;
        hold_v.ldp  = 1'b0;
        hold_v.tmb  = 1'b0;
        hold_v.bsc  = 2'd0;
        chk_state("R1 long", hold_v);

        // R8: reset mid-run clears everything
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk_state("R8 mid reset", zero_v);
        chk("R8 upd mid reset", 32'(upd), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule